// File: doc/BRIEF.md
# Cluster DMA Request Sequencer

This block is a single-channel DMA engine started by an external request line that is active low and sampled as a level. Each accepted request moves one cluster of `BEATS` words. The engine first reads those words back to back from the source address into a local buffer. It then writes them back to back to the destination address. A cluster counter sets how many requests the channel serves. When that counter runs out, the channel disables itself and raises a done flag.

The request line is sampled only while an acceptance window is open. The window opens on the clock edge that enables the channel. A sampled low level sets a held-request latch and closes the window. The latch clears when the engine commits to the cluster. The first read begins exactly three clock edges after the sampling edge. The window opens again on the edge that ends the cluster's last write, or one clock later when the delay bit is set.

Software programs the channel through a small write port. The bus side is a single-master handshake in which each cycle holds its address and direction until `bus_rdy` is seen high.

Top module: `dmac_cluster`

## Requirements
- R1: After reset, `bus_req`, `accept_open` and `done` are all low.
- R2: Writing the control register (`cfg_sel`=3) with bit 0 set, while the channel is off and the cluster count is non-zero, makes `accept_open` high from the next clock edge. With a count of zero the write is ignored and `accept_open` stays low. The register selects are 0 for source, 1 for destination and 2 for count.
- R3: The block latches a request only when it samples `req_n` low on an edge while `accept_open` is high. That edge drops `accept_open`. A high level on `req_n` leaves the window open and starts no bus cycle.
- R4: `bus_req` first rises in the cycle after the third clock edge that follows the sampling edge.
- R5: A cluster is `BEATS` reads (`bus_we`=0) at consecutive source addresses, followed by `BEATS` writes (`bus_we`=1) at consecutive destination addresses. The writes carry the data read, in the same order. Both addresses carry on from one cluster to the next.
- R6: While `bus_req` is high and `bus_rdy` is low, the bus address and direction do not change. A beat completes on the edge where `bus_rdy` is sampled high.
- R7: When control bit 1 (delay) is 0 and clusters remain, `accept_open` goes high on the same edge that completes the last write of a cluster.
- R8: When the delay bit is 1, `accept_open` goes high one clock edge after that last write.
- R9: When the final cluster completes, `done` goes high and `accept_open` stays low. No further bus cycles start, even if `req_n` stays low.
- R10: Writing the control register with bit 0 clear during a cluster lets the current bus cycle finish. No further bus cycle starts, the window closes, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Register write data; control bit 0 enables the channel, bit 1 selects the delay |
| req_n | input | 1 | Transfer request, active low, level sampled |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | AW | Word address of the bus cycle |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, taken when `bus_rdy` is high |
| bus_rdy | input | 1 | Ends the current bus cycle on this edge |
| accept_open | output | 1 | Acceptance window is open |
| done | output | 1 | All programmed clusters have been moved |

## Verification
The checker tests the following on every cycle:
- the window and the held request are never both set;
- a low sample in an open window latches the request;
- a cluster's first bus cycle has at least three idle cycles before it;
- a stalled bus cycle holds its address and direction;
- the window stays shut while a bus cycle runs or after completion.

Only the bench scenarios can show the exact reopen edge for each delay setting, the three-edge lead from sample to first read, and the data and address sequence across several clusters and wait-state counts. They also cover what happens after an abort and after completion.

// File: rtl/dmac_cluster_pkg.sv
// Package: shared state encoding and register map constants for the
// cluster DMA request sequencer. Assumes a two-bit register select.
package dmac_cluster_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD0,
        ST_LEAD1,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } seq_state_t;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_DLY_BIT = 1;

endpackage

// File: rtl/dmac_cfg_regs.sv
// Module: channel configuration registers.
// Holds the source and destination addresses, which advance one word per
// completed beat, the cluster counter, which counts down once per finished
// cluster, the enable and delay bits, and the done flag.
// Assumes CW <= AW and that the sequencer raises clus_end only while enabled.
module dmac_cfg_regs
    import dmac_cluster_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          rd_ack,
    input  logic          wr_ack,
    input  logic          clus_end,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic          en_q,
    output logic          dly_q,
    output logic          done_q,
    output logic          en_set
);

    logic ctl_wr;

    // Decode a control write and a valid off-to-on enable.
    always_comb begin
        ctl_wr = cfg_we && (cfg_sel == SEL_CTL);
        en_set = ctl_wr && cfg_wdata[CTL_EN_BIT] && !en_q && (cnt_q != '0);
    end

    // Update the address, count and control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            en_q   <= 1'b0;
            dly_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == SEL_SRC) begin
                src_q <= cfg_wdata;
            end else if (rd_ack) begin
                src_q <= src_q + AW'(1);
            end

            if (cfg_we && cfg_sel == SEL_DST) begin
                dst_q <= cfg_wdata;
            end else if (wr_ack) begin
                dst_q <= dst_q + AW'(1);
            end

            if (cfg_we && cfg_sel == SEL_CNT) begin
                cnt_q <= cfg_wdata[CW-1:0];
            end else if (clus_end) begin
                cnt_q <= cnt_q - CW'(1);
            end

            if (ctl_wr) begin
                en_q  <= en_set || (en_q && cfg_wdata[CTL_EN_BIT]);
                dly_q <= cfg_wdata[CTL_DLY_BIT];
                if (en_set) begin
                    done_q <= 1'b0;
                end
            end else if (clus_end && cnt_q == CW'(1)) begin
                en_q   <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmac_req_window.sv
// Module: acceptance window and held-request latch.
// Samples req_n on each edge while the window is open. A low level sets the
// held latch and shuts the window. The sequencer's start pulse clears the
// latch, and its reopen pulse opens the window again.
// Assumes start is raised only while held is set.
module dmac_req_window (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic en_set,
    input  logic start,
    input  logic reopen,
    input  logic req_n,
    output logic acc_q,
    output logic held_q
);

    // Manage the window and the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            held_q <= 1'b0;
        end else if (en_set) begin
            acc_q  <= 1'b1;
            held_q <= 1'b0;
        end else if (!en) begin
            acc_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            if (start) begin
                held_q <= 1'b0;
            end
            if (reopen) begin
                acc_q <= 1'b1;
            end else if (acc_q && !req_n) begin
                acc_q  <= 1'b0;
                held_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmac_cluster_seq.sv
// Module: cluster bus sequencer.
// On a held request it takes two lead states, then runs BEATS reads into a
// local buffer and BEATS writes out of it, then optionally one hold cycle
// before reopening the window. If en drops, the current bus cycle completes
// and the cluster is abandoned.
// Assumes 1 <= BEATS <= 8 and a bus that ends each cycle with rdy high.
module dmac_cluster_seq
    import dmac_cluster_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          held,
    input  logic          dly,
    input  logic          last_clu,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy,
    output logic          start,
    output logic          rd_ack,
    output logic          wr_ack,
    output logic          clus_end,
    output logic          reopen,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);

    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    seq_state_t    state_q;
    logic [BW-1:0] beat_q;
    logic [DW-1:0] buf_q [BEATS];
    logic          last_beat;

    // Drive the bus and the strobes from the current state.
    always_comb begin
        bus_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_we    = (state_q == ST_WRITE);
        bus_addr  = bus_we ? dst : src;
        bus_wdata = buf_q[beat_q];
        rd_ack    = (state_q == ST_READ) && bus_rdy;
        wr_ack    = (state_q == ST_WRITE) && bus_rdy;
        last_beat = (beat_q == LAST_BEAT);
        clus_end  = wr_ack && last_beat && en;
        start     = (state_q == ST_IDLE) && held && en;
        reopen    = (clus_end && !last_clu && !dly) || ((state_q == ST_HOLD) && en);
    end

    // Advance the cluster state machine and the beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_LEAD0;
                ST_LEAD0: state_q <= en ? ST_LEAD1 : ST_IDLE;
                ST_LEAD1: begin
                    state_q <= en ? ST_READ : ST_IDLE;
                    beat_q  <= '0;
                end
                ST_READ: if (bus_rdy) begin
                    if (!en) begin
                        state_q <= ST_IDLE;
                    end else if (last_beat) begin
                        state_q <= ST_WRITE;
                        beat_q  <= '0;
                    end else begin
                        beat_q <= beat_q + BW'(1);
                    end
                end
                ST_WRITE: if (bus_rdy) begin
                    if (!en) begin
                        state_q <= ST_IDLE;
                    end else if (last_beat) begin
                        state_q <= (last_clu || !dly) ? ST_IDLE : ST_HOLD;
                    end else begin
                        beat_q <= beat_q + BW'(1);
                    end
                end
                ST_HOLD:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture read data into the buffer slot of the current beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BEATS; i++) buf_q[i] <= '0;
        end else if (rd_ack) begin
            buf_q[beat_q] <= bus_rdata;
        end
    end

endmodule

// File: rtl/dmac_cluster.sv
// Module: top of the cluster DMA request sequencer.
// Connects the configuration registers, the acceptance window and the bus
// sequencer for one channel. Assumes a single bus master and CW <= AW.
module dmac_cluster #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CW    = 8,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_n,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy,
    output logic          accept_open,
    output logic          done
);

    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic          en_q, dly_q, en_set;
    logic          acc_q, held_q;
    logic          start, rd_ack, wr_ack, clus_end, reopen;
    logic          last_clu;

    // Flag the final cluster of the programmed transfer.
    always_comb last_clu = (cnt_q == CW'(1));

    dmac_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .clus_end(clus_end), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
        .en_q(en_q), .dly_q(dly_q), .done_q(done), .en_set(en_set)
    );

    dmac_req_window u_win (
        .clk(clk), .rst_n(rst_n), .en(en_q), .en_set(en_set), .start(start),
        .reopen(reopen), .req_n(req_n), .acc_q(acc_q), .held_q(held_q)
    );

    dmac_cluster_seq #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .held(held_q), .dly(dly_q),
        .last_clu(last_clu), .src(src_q), .dst(dst_q), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .start(start), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .clus_end(clus_end), .reopen(reopen), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    assign accept_open = acc_q;

endmodule

// File: rtl/dmac_cluster_chk.sv
// Module: assertion checker bound to dmac_cluster.
// Watches the window, the held latch and the bus handshake on every cycle.
module dmac_cluster_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          req_n,
    input logic          en,
    input logic          acc,
    input logic          held,
    input logic          done,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rdy
);

    // R3: the open window and the held request never coexist.
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> !held);

    // R3: a low sample in an open window latches and shuts the window.
    p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_n && en && !cfg_we) |=> (held && !acc));

    // R4: a cluster's first bus cycle is a read with at least three idle cycles before it.
    p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (!bus_we && !$past(bus_req, 2) && !$past(bus_req, 3)));

    // R6: a stalled bus cycle keeps its address and direction.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R7: the window stays shut while a bus cycle runs.
    p_busy_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !acc);

    // R9: once the transfer is complete, nothing is accepted or held.
    p_done_shut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!acc && !held && !en));

endmodule

bind dmac_cluster dmac_cluster_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_n(req_n), .en(en_q),
    .acc(acc_q), .held(held_q), .done(done), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdy(bus_rdy)
);

// File: tb/sim_dmac_cluster.sv
module sim_dmac_cluster;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int B  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_n = 1'b1;
    logic          bus_req, bus_we, accept_open, done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_rdy = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wt     = 0;
    int wcnt   = 0;
    int ntx    = 0;
    int last_wr_cyc = 0;
    logic [AW-1:0] beat_addr = '0;
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    logic          log_we   [64];

    dmac_cluster #(.AW(AW), .DW(DW), .CW(8), .BEATS(B)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_n(req_n), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
        .accept_open(accept_open), .done(done)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h33};
    endfunction

    assign bus_rdata = data_of(bus_addr);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Bus model: answers after wt wait cycles and logs each completed beat.
    always @(negedge clk) begin
        if (bus_rdy) begin
            bus_rdy = 1'b0;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt == 0) beat_addr = bus_addr;
            if (wcnt == wt) begin
                check(bus_addr == beat_addr, "R6 stalled address", int'(bus_addr), int'(beat_addr));
                if (ntx < 64) begin
                    log_addr[ntx] = bus_addr;
                    log_we[ntx]   = bus_we;
                    log_data[ntx] = bus_we ? bus_wdata : bus_rdata;
                end
                ntx++;
                if (bus_we) last_wr_cyc = cyc;
                bus_rdy = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic run_scenario(input int dly, input int ncl, input logic [AW-1:0] src,
                                input logic [AW-1:0] dst);
        int k;
        int guard;
        ntx = 0;
        cfg_write(2'd0, src);
        cfg_write(2'd1, dst);
        cfg_write(2'd2, AW'(ncl));
        cfg_write(2'd3, AW'({dly[0], 1'b1}));
        check(accept_open == 1'b1, "R2 window after enable", int'(accept_open), 1);
        // R3: a high level keeps the window open and starts nothing.
        repeat (5) @(negedge clk);
        check(accept_open == 1'b1 && bus_req == 1'b0 && ntx == 0, "R3 high ignored",
              int'(accept_open), 1);
        for (int c = 0; c < ncl; c++) begin
            guard = 0;
            while (!accept_open && guard < 400) begin
                @(negedge clk);
                guard++;
            end
            if (c > 0) begin
                check(cyc - last_wr_cyc == 1 + dly, dly ? "R8 delayed reopen" : "R7 reopen",
                      cyc - last_wr_cyc, 1 + dly);
            end
            req_n = 1'b0;
            k = cyc;
            @(negedge clk);
            req_n = 1'b1;
            check(accept_open == 1'b0, "R3 window shut after sample", int'(accept_open), 0);
            guard = 0;
            while (!bus_req && guard < 50) begin
                @(negedge clk);
                guard++;
            end
            check(cyc - k == 4, "R4 lead to first read", cyc - k, 4);
            guard = 0;
            while (ntx < (c + 1) * 2 * B && guard < 400) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R9 done raised", int'(done), 1);
        check(accept_open == 1'b0, "R9 window shut", int'(accept_open), 0);
        req_n = 1'b0;
        repeat (12) @(negedge clk);
        req_n = 1'b1;
        check(ntx == ncl * 2 * B, "R9 no extra beats", ntx, ncl * 2 * B);
        for (int c = 0; c < ncl; c++) begin
            for (int i = 0; i < B; i++) begin
                int r = c * 2 * B + i;
                int w = r + B;
                logic [AW-1:0] sa = src + AW'(c * B + i);
                logic [AW-1:0] da = dst + AW'(c * B + i);
                check(log_addr[r] == sa && !log_we[r] && log_data[r] == data_of(sa),
                      "R5 read beat", int'(log_addr[r]), int'(sa));
                check(log_addr[w] == da && log_we[w] && log_data[w] == data_of(sa),
                      "R5 write beat", int'(log_data[w]), int'(data_of(sa)));
            end
        end
    endtask

    initial begin
        int guard;
        repeat (3) @(negedge clk);
        check(bus_req == 1'b0 && accept_open == 1'b0 && done == 1'b0, "R1 reset state",
              int'({bus_req, accept_open, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_req == 1'b0 && accept_open == 1'b0 && done == 1'b0, "R1 after release",
              int'({bus_req, accept_open, done}), 0);

        // R2: enabling with a zero count is ignored.
        cfg_write(2'd2, '0);
        cfg_write(2'd3, AW'(1));
        check(accept_open == 1'b0, "R2 zero count ignored", int'(accept_open), 0);
        cfg_write(2'd3, '0);

        for (int d = 0; d < 2; d++) begin
            for (int w = 0; w < 3; w++) begin
                for (int n = 1; n <= 3; n++) begin
                    wt = w;
                    run_scenario(d, n, AW'(16'h0100 + 16'h40 * n + 16'h10 * w),
                                 AW'(16'h8000 + 16'h100 * d + 16'h20 * n));
                end
            end
        end

        // R10: disabling during a cluster finishes the current beat only.
        wt = 2;
        ntx = 0;
        cfg_write(2'd0, AW'(16'h2000));
        cfg_write(2'd1, AW'(16'h3000));
        cfg_write(2'd2, AW'(4));
        cfg_write(2'd3, AW'(1));
        req_n = 1'b0;
        @(negedge clk);
        req_n = 1'b1;
        guard = 0;
        while (ntx < 2 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        cfg_write(2'd3, '0);
        repeat (20) @(negedge clk);
        check(ntx == 3, "R10 current beat completes", ntx, 3);
        check(bus_req == 1'b0 && accept_open == 1'b0, "R10 idle after abort",
              int'({bus_req, accept_open}), 0);
        check(done == 1'b0, "R10 done stays low", int'(done), 0);
        req_n = 1'b0;
        repeat (20) @(negedge clk);
        req_n = 1'b1;
        check(ntx == 3, "R10 request ignored after abort", ntx, 3);

        summary();
    end

endmodule